// File: doc/BRIEF.md
# Profiling Record Filter

This block sits between the stage that finishes collecting one profiling sample and the stage that stores it. Each finished sample arrives as one record holding an operation kind, a latency in cycles and a 16-bit event vector. The block tests the record against three programmable criteria: per-kind enables, a required-event mask and a latency threshold. A record that meets all three is kept, and one that misses any of them is discarded.

The decision comes out one cycle after the record is accepted, as a one-cycle keep or discard pulse. A kept record is then held on a valid/ready output until the consumer takes it, and no new record is accepted while it waits. A discarded record is consumed and produces no output, so the next record can be accepted at once. Two saturating counters give the number of kept and discarded records.

Top module: `rec_filter`

## Requirements
- R1: After reset, out_valid_o, keep_o and drop_o are 0, both counters are 0, and in_ready_o is 1.
- R2: Kind codes are 0 = load, 1 = store, 2 = branch and 3 = other. Enable bit 0 admits loads, bit 1 admits stores and bit 2 admits branches. When any enable bit is set, a record passes the kind test only if the enable bit for its kind is set. Kind 3 never passes while any enable bit is set.
- R3: When all three enable bits are 0, every kind passes the kind test.
- R4: A record passes the event test only if every bit set in the mask is also set in its event vector. The event bit meanings are: bit 1 = retired, bit 3 = L1 data refill, bit 5 = TLB refill, bit 7 = mispredict, bit 11 = misaligned access.
- R5: With a nonzero threshold, a record passes the latency test only if its latency is greater than or equal to the threshold. A threshold of 0 passes every latency.
- R6: In the cycle after a record is accepted, exactly one of keep_o and drop_o is high, for one cycle. Neither is high in any other cycle.
- R7: A kept record appears on out_kind_o, out_lat_o and out_evt_o with out_valid_o high. These outputs hold steady until a cycle in which out_ready_i is high.
- R8: in_ready_o is low in every cycle in which out_valid_o is high.
- R9: A discarded record never raises out_valid_o. in_ready_o stays high after a discard, so records that are all discarded can be accepted on consecutive cycles.
- R10: kept_cnt_o counts kept records and drop_cnt_o counts discarded records. Each counter stops at 0xFFFF and does not wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | A record is offered on the input |
| in_ready_o | output | 1 | The block can accept a record |
| in_kind_i | input | 2 | Operation kind of the record |
| in_lat_i | input | 12 | Latency of the record, in cycles |
| in_evt_i | input | 16 | Event vector of the record |
| cfg_kind_en_i | input | 3 | Kind enables: bit 0 load, bit 1 store, bit 2 branch |
| cfg_evt_mask_i | input | 16 | Events that a record must have to be kept |
| cfg_min_lat_i | input | 12 | Latency threshold; 0 turns the latency test off |
| out_valid_o | output | 1 | A kept record is waiting on the output |
| out_ready_i | input | 1 | The consumer takes the record |
| out_kind_o | output | 2 | Kind of the kept record |
| out_lat_o | output | 12 | Latency of the kept record |
| out_evt_o | output | 16 | Event vector of the kept record |
| keep_o | output | 1 | One-cycle pulse: the record was kept |
| drop_o | output | 1 | One-cycle pulse: the record was discarded |
| kept_cnt_o | output | 16 | Saturating count of kept records |
| drop_cnt_o | output | 16 | Saturating count of discarded records |

## Verification
The bench probes the latency threshold at one below, exactly at, and one above the threshold, and also at the full-scale value. A comparison that is off by one, or that tests strictly greater, drops the record that sits exactly on the threshold.

Event masks with two bits set are tested against records that carry only one of them. A design that checks for any overlap instead of all bits would keep such a record. The "other" kind is sent with enables both clear and set, and so are records of two enabled kinds. This catches a kind test that is inverted or that treats an all-zero enable set as "reject everything".

About 65 thousand back-to-back discards push the discard counter to its limit, and the bench confirms the counter does not wrap to zero. The bench also holds off the consumer. It confirms that the output stays steady, that in_ready_o stays low, and that the decision pulse does not stretch over the wait.

// File: rtl/rf_pkg.sv
package rf_pkg;
  localparam int unsigned KIND_W = 2;
  localparam int unsigned N_KIND = 3;
  localparam int unsigned LAT_W  = 12;
  localparam int unsigned EVT_W  = 16;
  localparam int unsigned CNT_W  = 16;

  typedef enum logic [KIND_W-1:0] {
    KIND_LOAD   = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2,
    KIND_OTHER  = 2'd3
  } kind_e;

  // fixed event bit positions
  localparam int unsigned EV_RETIRED  = 1;
  localparam int unsigned EV_L1D_FILL = 3;
  localparam int unsigned EV_TLB_FILL = 5;
  localparam int unsigned EV_MISPRED  = 7;
  localparam int unsigned EV_UNALIGN  = 11;
endpackage

// File: rtl/rf_match.sv
module rf_match #(
  parameter int unsigned KIND_W = rf_pkg::KIND_W,
  parameter int unsigned N_KIND = rf_pkg::N_KIND,
  parameter int unsigned LAT_W  = rf_pkg::LAT_W,
  parameter int unsigned EVT_W  = rf_pkg::EVT_W
) (
  input  logic [KIND_W-1:0] kind_i,
  input  logic [LAT_W-1:0]  lat_i,
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [N_KIND-1:0] kind_en_i,
  input  logic [EVT_W-1:0]  evt_mask_i,
  input  logic [LAT_W-1:0]  min_lat_i,
  output logic              pass_o
);
  logic [N_KIND-1:0] kind_hit;
  logic type_ok, evt_ok, lat_ok;

  for (genvar t = 0; t < N_KIND; t++) begin : g_kind
    assign kind_hit[t] = kind_en_i[t] && (kind_i == KIND_W'(t));
  end

  always_comb begin
    type_ok = (kind_en_i == '0) || (|kind_hit);
    evt_ok  = ((evt_i & evt_mask_i) == evt_mask_i);
    lat_ok  = (min_lat_i == '0) || (lat_i >= min_lat_i);
    pass_o  = type_ok && evt_ok && lat_ok;
  end
endmodule

// File: rtl/rf_sat_cnt.sv
module rf_sat_cnt #(
  parameter int unsigned W = rf_pkg::CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (inc_i && cnt_o != MAX)  cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/rf_hold.sv
module rf_hold #(
  parameter int unsigned DW = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [DW-1:0] data_i,
  input  logic          ready_i,
  output logic          valid_o,
  output logic [DW-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rec_filter.sv
module rec_filter
  import rf_pkg::*;
#(
  parameter int unsigned LW = LAT_W,
  parameter int unsigned EW = EVT_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [KIND_W-1:0] in_kind_i,
  input  logic [LW-1:0]     in_lat_i,
  input  logic [EW-1:0]     in_evt_i,
  input  logic [N_KIND-1:0] cfg_kind_en_i,
  input  logic [EW-1:0]     cfg_evt_mask_i,
  input  logic [LW-1:0]     cfg_min_lat_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic [KIND_W-1:0] out_kind_o,
  output logic [LW-1:0]     out_lat_o,
  output logic [EW-1:0]     out_evt_o,
  output logic              keep_o,
  output logic              drop_o,
  output logic [CW-1:0]     kept_cnt_o,
  output logic [CW-1:0]     drop_cnt_o
);
  localparam int unsigned DW = KIND_W + LW + EW;

  logic pass, acc, acc_keep, acc_drop;
  logic [DW-1:0] hold_q;

  assign in_ready_o = !out_valid_o;
  assign acc        = in_valid_i && in_ready_o;
  assign acc_keep   = acc && pass;
  assign acc_drop   = acc && !pass;

  rf_match #(.KIND_W(KIND_W), .N_KIND(N_KIND), .LAT_W(LW), .EVT_W(EW)) u_match (
    .kind_i     (in_kind_i),
    .lat_i      (in_lat_i),
    .evt_i      (in_evt_i),
    .kind_en_i  (cfg_kind_en_i),
    .evt_mask_i (cfg_evt_mask_i),
    .min_lat_i  (cfg_min_lat_i),
    .pass_o     (pass)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      keep_o <= 1'b0;
      drop_o <= 1'b0;
    end else begin
      keep_o <= acc_keep;
      drop_o <= acc_drop;
    end
  end

  rf_hold #(.DW(DW)) u_hold (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (acc_keep),
    .data_i  ({in_kind_i, in_lat_i, in_evt_i}),
    .ready_i (out_ready_i),
    .valid_o (out_valid_o),
    .data_o  (hold_q)
  );

  assign {out_kind_o, out_lat_o, out_evt_o} = hold_q;

  rf_sat_cnt #(.W(CW)) u_kept_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .inc_i(acc_keep), .cnt_o(kept_cnt_o)
  );
  rf_sat_cnt #(.W(CW)) u_drop_cnt (
    .clk_i (clk_i), .rst_ni(rst_ni), .inc_i(acc_drop), .cnt_o(drop_cnt_o)
  );
endmodule

// File: rtl/rf_chk.sv
module rf_chk
  import rf_pkg::*;
#(
  parameter int unsigned LW = LAT_W,
  parameter int unsigned EW = EVT_W,
  parameter int unsigned CW = CNT_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              in_valid_i,
  input logic              in_ready_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [KIND_W-1:0] out_kind_o,
  input logic [LW-1:0]     out_lat_o,
  input logic [EW-1:0]     out_evt_o,
  input logic              keep_o,
  input logic              drop_o,
  input logic [CW-1:0]     kept_cnt_o,
  input logic [CW-1:0]     drop_cnt_o
);
  localparam logic [CW-1:0] MAX = '1;

  a_r6_one_verdict: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(keep_o && drop_o));
  a_r6_verdict_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> (keep_o || drop_o));
  a_r6_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (keep_o || drop_o) |-> $past(in_valid_i && in_ready_o));
  a_r7_hold_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_kind_o) && $stable(out_lat_o) && $stable(out_evt_o)));
  a_r8_busy_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> !in_ready_o);
  a_r9_out_from_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> keep_o);
  a_r10_kept_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kept_cnt_o == MAX) |=> (kept_cnt_o == MAX));
  a_r10_drop_sat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drop_cnt_o == MAX) |=> (drop_cnt_o == MAX));
endmodule

bind rec_filter rf_chk #(.LW(LW), .EW(EW), .CW(CW)) u_rf_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .in_valid_i  (in_valid_i),
  .in_ready_o  (in_ready_o),
  .out_valid_o (out_valid_o),
  .out_ready_i (out_ready_i),
  .out_kind_o  (out_kind_o),
  .out_lat_o   (out_lat_o),
  .out_evt_o   (out_evt_o),
  .keep_o      (keep_o),
  .drop_o      (drop_o),
  .kept_cnt_o  (kept_cnt_o),
  .drop_cnt_o  (drop_cnt_o)
);

// File: tb/tb_rec_filter.sv
module tb_rec_filter;
  import rf_pkg::*;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WD_CYCLES  = 150000;
  localparam int  NV         = 21;
  // {en[3], mask[16], thr[12], kind[2], lat[12], evt[16], keep[1]}
  localparam logic [61:0] VEC [NV] = '{
    {3'b000, 16'h0000, 12'd0,   2'd0, 12'd5,    16'h0000, 1'b1}, // R3 all off
    {3'b001, 16'h0000, 12'd0,   2'd0, 12'd5,    16'h0000, 1'b1}, // R2 load
    {3'b001, 16'h0000, 12'd0,   2'd1, 12'd5,    16'h0000, 1'b0}, // R2
    {3'b010, 16'h0000, 12'd0,   2'd1, 12'd5,    16'h0000, 1'b1}, // R2 store
    {3'b100, 16'h0000, 12'd0,   2'd2, 12'd5,    16'h0000, 1'b1}, // R2 branch
    {3'b100, 16'h0000, 12'd0,   2'd0, 12'd5,    16'h0000, 1'b0}, // R2
    {3'b011, 16'h0000, 12'd0,   2'd2, 12'd5,    16'h0000, 1'b0}, // R2
    {3'b011, 16'h0000, 12'd0,   2'd1, 12'd5,    16'h0000, 1'b1}, // R2 any-of
    {3'b000, 16'h0000, 12'd0,   2'd3, 12'd5,    16'h0000, 1'b1}, // R3 other
    {3'b111, 16'h0000, 12'd0,   2'd3, 12'd5,    16'h0000, 1'b0}, // R2 other
    {3'b000, 16'h0002, 12'd0,   2'd0, 12'd5,    16'h0002, 1'b1}, // R4 retired
    {3'b000, 16'h0002, 12'd0,   2'd0, 12'd5,    16'h0800, 1'b0}, // R4
    {3'b000, 16'h0088, 12'd0,   2'd0, 12'd5,    16'h0080, 1'b0}, // R4 partial
    {3'b000, 16'h0088, 12'd0,   2'd0, 12'd5,    16'h08AA, 1'b1}, // R4 superset
    {3'b000, 16'h0000, 12'd10,  2'd0, 12'd9,    16'h0000, 1'b0}, // R5 below
    {3'b000, 16'h0000, 12'd10,  2'd0, 12'd10,   16'h0000, 1'b1}, // R5 equal
    {3'b000, 16'h0000, 12'd10,  2'd0, 12'd11,   16'h0000, 1'b1}, // R5 above
    {3'b000, 16'h0000, 12'hFFF, 2'd0, 12'hFFF,  16'h0000, 1'b1}, // R5 full scale
    {3'b000, 16'h0000, 12'd1,   2'd0, 12'd0,    16'h0000, 1'b0}, // R5
    {3'b001, 16'h0020, 12'd100, 2'd0, 12'd200,  16'h0020, 1'b1}, // R2 R4 R5
    {3'b001, 16'h0020, 12'd100, 2'd0, 12'd50,   16'h0020, 1'b0}  // R5
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b0;
  logic [1:0] in_kind = '0, out_kind;
  logic [11:0] in_lat = '0, cfg_min_lat = '0, out_lat;
  logic [15:0] in_evt = '0, cfg_mask = '0, out_evt;
  logic [2:0] cfg_en = '0;
  logic keep, drop;
  logic [15:0] kept_cnt, drop_cnt;
  int checks = 0, fails = 0;
  int exp_kept = 0, exp_drop = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rec_filter dut (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .in_kind_i(in_kind), .in_lat_i(in_lat), .in_evt_i(in_evt),
    .cfg_kind_en_i(cfg_en), .cfg_evt_mask_i(cfg_mask), .cfg_min_lat_i(cfg_min_lat),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .out_kind_o(out_kind),
    .out_lat_o(out_lat), .out_evt_o(out_evt), .keep_o(keep), .drop_o(drop),
    .kept_cnt_o(kept_cnt), .drop_cnt_o(drop_cnt)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    in_valid = 1'b0; out_ready = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    exp_kept = 0; exp_drop = 0;
  endtask

  function automatic int sat(int v);
    return (v >= 16'hFFFF) ? 16'hFFFF : v + 1;
  endfunction

  task automatic run_one(logic [61:0] v, int idx);
    logic exp_keep;
    @(negedge clk);
    {cfg_en, cfg_mask, cfg_min_lat, in_kind, in_lat, in_evt, exp_keep} = v;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (exp_keep) exp_kept = sat(exp_kept); else exp_drop = sat(exp_drop);
    check($sformatf("R2/R3/R4/R5 keep vec%0d", idx), keep, exp_keep);
    check($sformatf("R6 drop vec%0d", idx), drop, !exp_keep);
    check($sformatf("R9 out_valid vec%0d", idx), out_valid, exp_keep);
    check($sformatf("R10 kept_cnt vec%0d", idx), kept_cnt, exp_kept);
    check($sformatf("R10 drop_cnt vec%0d", idx), drop_cnt, exp_drop);
    if (exp_keep) begin
      check("R7 out fields", {out_kind, out_lat, out_evt}, {in_kind, in_lat, in_evt});
      check("R8 ready low", in_ready, 1'b0);
      @(negedge clk);
      check("R6 keep pulse ends", keep, 1'b0);
      check("R7 still valid", out_valid, 1'b1);
      check("R7 fields steady", {out_kind, out_lat, out_evt}, {in_kind, in_lat, in_evt});
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      check("R7 taken", out_valid, 1'b0);
      check("R8 ready back", in_ready, 1'b1);
    end else begin
      check("R9 ready after drop", in_ready, 1'b1);
      @(negedge clk);
      check("R6 drop pulse ends", drop, 1'b0);
      check("R9 no output", out_valid, 1'b0);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 out_valid", out_valid, 1'b0);
    check("R1 keep", keep, 1'b0);
    check("R1 drop", drop, 1'b0);
    check("R1 kept_cnt", kept_cnt, 0);
    check("R1 drop_cnt", drop_cnt, 0);
    check("R1 in_ready", in_ready, 1'b1);

    for (int i = 0; i < NV; i++) run_one(VEC[i], i);

    // R8: offered record is not taken while a kept one waits
    @(negedge clk);
    cfg_en = '0; cfg_mask = '0; cfg_min_lat = '0;
    in_kind = 2'd1; in_lat = 12'd7; in_evt = 16'h0002; in_valid = 1'b1;
    @(negedge clk);
    in_kind = 2'd2; in_lat = 12'd99; in_evt = 16'h0800;
    exp_kept = sat(exp_kept);
    repeat (3) @(negedge clk);
    check("R8 blocked, first held", {out_kind, out_lat, out_evt}, {2'd1, 12'd7, 16'h0002});
    check("R8 counter unchanged", kept_cnt, exp_kept);
    check("R8 no verdict while blocked", keep | drop, 1'b0);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check("R8 second record not taken", kept_cnt, exp_kept);

    // R10 + R9: back-to-back discards up to saturation
    do_reset();
    @(negedge clk);
    cfg_mask = 16'hFFFF; in_evt = 16'h0000; in_valid = 1'b1;
    repeat (65540) @(negedge clk);
    in_valid = 1'b0;
    check("R9 no output during drop stream", out_valid, 1'b0);
    check("R10 drop saturates", drop_cnt, 16'hFFFF);
    exp_drop = 16'hFFFF;
    run_one({3'b000, 16'h0000, 12'd0, 2'd0, 12'd3, 16'h0000, 1'b1}, 100);
    run_one({3'b000, 16'h0001, 12'd0, 2'd0, 12'd3, 16'h0000, 1'b0}, 101);
    check("R10 drop stays at max", drop_cnt, 16'hFFFF);

    // R1: reset while a kept record waits
    @(negedge clk);
    cfg_mask = '0; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    do_reset();
    @(negedge clk);
    check("R1 reset clears waiting out", out_valid, 1'b0);
    check("R1 reset clears counts", {kept_cnt, drop_cnt}, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule